// File: doc/BRIEF.md
# Byte-Wide JTAG Scan Engine

This block is a JTAG master driven by a byte-wide host port. The host writes a configuration byte to set up the next scans. It then writes a data byte that launches a scan of up to eight bits onto either TMS or TDI. The engine generates TCK at a selectable fraction of the system clock and captures TDO on every rising TCK edge. After the scan the host reads the captured bits back.

The configuration byte also drives the system-reset and TAP-reset outputs as static levels. A TDI scan keeps TMS low, so the TAP stays in a shift state. A TMS scan holds TDI at data bit 7 for the whole scan, so the final data bit of a register can be shifted while the TAP leaves the shift state. A busy flag covers the whole scan. The host must not issue new writes while the flag is high; any such write is dropped.

Top module: `jtag_byte_engine`

## Requirements
- R1: After reset, busy_o, tck_o, tms_o, tdi_o, srst_o, trst_o and rdata_o are all 0.
- R2: A configuration write (cfg_we_i while idle) latches wdata_i. Bit 6 drives srst_o and bit 7 drives trst_o, and both hold until the next accepted configuration write.
- R3: Configuration bits [2:0] give the scan length N. Code 0 means 8 bits and codes 1 to 7 mean that many bits. A scan produces exactly N TCK rising edges.
- R4: With configuration bit 3 = 0 (TDI target), tdi_o presents data bit k at the k-th TCK rise (LSB first) and tms_o is 0 throughout.
- R5: With configuration bit 3 = 1 (TMS target), tms_o presents data bit k at the k-th TCK rise (LSB first) and tdi_o equals data bit 7 throughout.
- R6: Configuration bits [5:4] hold the divider code D. Each TCK half-period lasts 2^D clock cycles, so TCK runs at clk/2, clk/4, clk/8 or clk/16. TCK is low whenever the engine is idle.
- R7: TDO is sampled at each TCK rise. At scan end, rdata_o bit k holds the TDO value seen at rise k, for k below N, and the bits above N-1 read 0.
- R8: busy_o rises at the clock edge that accepts a scan write and stays high for exactly 2*N*2^D cycles.
- R9: Configuration or scan writes presented while busy_o is high are ignored. The reset outputs keep their values and the running scan neither restarts nor lengthens.
- R10: During a scan, rdata_o keeps the result of the previous completed scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| scan_we_i | input | 1 | Scan launch strobe |
| wdata_i | input | 8 | Host write data (configuration or scan byte) |
| rdata_o | output | 8 | Result of the last completed scan |
| busy_o | output | 1 | Scan in progress |
| tck_o | output | 1 | JTAG test clock |
| tms_o | output | 1 | JTAG mode select |
| tdi_o | output | 1 | JTAG data to target |
| tdo_i | input | 1 | JTAG data from target |
| srst_o | output | 1 | System reset level, from configuration bit 6 |
| trst_o | output | 1 | TAP reset level, from configuration bit 7 |

## Verification
The checker expects writes to be single-cycle strobes with wdata_i settled at the sampling edge. It also expects the host to leave no obligation on the block while busy, so dropped writes must leave no trace on the JTAG pins or on the reset levels. The stimulus draws configuration, scan data and TDO patterns from a seeded $urandom stream. Writes change only on the falling clock edge. tdo_i changes only just after each TCK rise, which keeps it stable at every sampling edge. On about half of the scans the bench deliberately pulses both write strobes at a random busy cycle, which exercises the drop path.

// File: rtl/jtag_eng_pkg.sv
package jtag_eng_pkg;
  localparam int DW    = 8;
  localparam int NB_W  = 3;
  localparam int DIV_W = 2;

  // bit order fixed by host protocol: [7] trst, [6] srst, [5:4] div, [3] tms target, [2:0] count
  typedef struct packed {
    logic             trst;
    logic             srst;
    logic [DIV_W-1:0] div;
    logic             tgt_tms;
    logic [NB_W-1:0]  nbits;
  } cfg_t;
endpackage

// File: rtl/jtag_eng_cfg.sv
module jtag_eng_cfg
  import jtag_eng_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output cfg_t          cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_o <= '0;
    else if (we_i) cfg_o <= cfg_t'(wdata_i);
  end
endmodule

// File: rtl/jtag_eng_clkgen.sv
module jtag_eng_clkgen #(
  parameter int DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim    = CNT_W'((32'd1 << div_i) - 32'd1);
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/jtag_eng_shift.sv
module jtag_eng_shift #(
  parameter int DW   = 8,
  parameter int NB_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            tick_i,
  input  logic            tgt_tms_i,
  input  logic [NB_W-1:0] nbits_i,
  input  logic [DW-1:0]   data_i,
  input  logic            tdo_i,
  output logic            busy_o,
  output logic            tck_o,
  output logic            tms_o,
  output logic            tdi_o,
  output logic [DW-1:0]   rdata_o
);
  localparam int LW = NB_W + 1;

  logic          busy_q, tck_q, tgt_q, hold_q;
  logic [LW-1:0] left_q, n_q, n_load;
  logic [DW-1:0] sh_q, cap_q, res_q;

  assign n_load = (nbits_i == '0) ? LW'(DW) : {1'b0, nbits_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tck_q  <= 1'b0;
      tgt_q  <= 1'b0;
      hold_q <= 1'b0;
      left_q <= '0;
      n_q    <= '0;
      sh_q   <= '0;
      cap_q  <= '0;
      res_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      tck_q  <= 1'b0;
      tgt_q  <= tgt_tms_i;
      hold_q <= data_i[DW-1];
      left_q <= n_load;
      n_q    <= n_load;
      sh_q   <= data_i;
      cap_q  <= '0;
    end else if (busy_q && tick_i) begin
      if (!tck_q) begin
        tck_q <= 1'b1;
        cap_q <= {tdo_i, cap_q[DW-1:1]};  // fill from MSB, align at end
      end else begin
        tck_q  <= 1'b0;
        sh_q   <= sh_q >> 1;
        left_q <= left_q - 1'b1;
        if (left_q == LW'(1)) begin
          busy_q <= 1'b0;
          res_q  <= cap_q >> (LW'(DW) - n_q);
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign tck_o   = tck_q;
  assign tms_o   = busy_q & tgt_q & sh_q[0];
  assign tdi_o   = busy_q & (tgt_q ? hold_q : sh_q[0]);
  assign rdata_o = res_q;
endmodule

// File: rtl/jtag_byte_engine.sv
module jtag_byte_engine
  import jtag_eng_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic          scan_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          busy_o,
  output logic          tck_o,
  output logic          tms_o,
  output logic          tdi_o,
  input  logic          tdo_i,
  output logic          srst_o,
  output logic          trst_o
);
  cfg_t cfg;
  logic busy, tick, start, cfg_we;

  assign cfg_we = cfg_we_i & ~busy;
  assign start  = scan_we_i & ~busy;

  jtag_eng_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we),
    .wdata_i (wdata_i),
    .cfg_o   (cfg)
  );

  jtag_eng_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .div_i  (cfg.div),
    .tick_o (tick)
  );

  jtag_eng_shift #(.DW(DW), .NB_W(NB_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .tick_i    (tick),
    .tgt_tms_i (cfg.tgt_tms),
    .nbits_i   (cfg.nbits),
    .data_i    (wdata_i),
    .tdo_i     (tdo_i),
    .busy_o    (busy),
    .tck_o     (tck_o),
    .tms_o     (tms_o),
    .tdi_o     (tdi_o),
    .rdata_o   (rdata_o)
  );

  assign busy_o = busy;
  assign srst_o = cfg.srst;
  assign trst_o = cfg.trst;
endmodule

// File: rtl/jtag_eng_chk.sv
module jtag_eng_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_we_i,
  input logic       busy_o,
  input logic       tck_o,
  input logic       tms_o,
  input logic       tdi_o,
  input logic       srst_o,
  input logic       trst_o,
  input logic [7:0] rdata_o
);
  // R6
  idle_pins_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!tck_o && !tms_o && !tdi_o));

  // R6
  tck_only_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tck_o) |-> $past(busy_o));

  // R9
  busy_cfg_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cfg_we_i) |=> ($stable(srst_o) && $stable(trst_o)));

  // R10
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(rdata_o));

  // R8
  busy_ends_low_tck_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !tck_o);
endmodule

bind jtag_byte_engine jtag_eng_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cfg_we_i (cfg_we_i),
  .busy_o   (busy_o),
  .tck_o    (tck_o),
  .tms_o    (tms_o),
  .tdi_o    (tdi_o),
  .srst_o   (srst_o),
  .trst_o   (trst_o),
  .rdata_o  (rdata_o)
);

// File: tb/jtag_byte_engine_test.sv
module jtag_byte_engine_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0, scan_we = 1'b0, tdo = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       busy, tck, tms, tdi, srst, trst;

  int unsigned n_chk = 0, n_bad = 0;
  logic [7:0] pat;
  int         nr;
  logic       rec_tdi [16];
  logic       rec_tms [16];

  always #5 clk = ~clk;

  jtag_byte_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .scan_we_i(scan_we),
    .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy), .tck_o(tck),
    .tms_o(tms), .tdi_o(tdi), .tdo_i(tdo), .srst_o(srst), .trst_o(trst)
  );

  // TCK-side target model: record pins at each rise, present next TDO bit
  always @(posedge tck) begin
    if (nr < 16) begin
      rec_tdi[nr] = tdi;
      rec_tms[nr] = tms;
    end
    nr = nr + 1;
    tdo = (nr < 8) ? pat[nr] : 1'b0;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int scan_len(input logic [7:0] c);
    return (c[2:0] == 3'd0) ? 8 : int'(c[2:0]);
  endfunction

  function automatic logic [7:0] exp_result(input logic [7:0] p, input int n);
    return (n == 8) ? p : (p & 8'((1 << n) - 1));
  endfunction

  function automatic bit bits_ok(input logic [7:0] c, input logic [7:0] d, input int n);
    for (int k = 0; k < n; k++) begin
      if (c[3]) begin
        if (rec_tms[k] !== d[k] || rec_tdi[k] !== d[7]) return 1'b0;
      end else begin
        if (rec_tdi[k] !== d[k] || rec_tms[k] !== 1'b0) return 1'b0;
      end
    end
    return 1'b1;
  endfunction

  logic [7:0] prev_res = '0;

  task automatic do_scan(input logic [7:0] c, input logic [7:0] d, input logic [7:0] p, input bit inject);
    int n, cyc, want, inj;
    n    = scan_len(c);
    want = 2 * n * (1 << c[5:4]);
    inj  = inject ? (1 + int'($urandom % (want > 1 ? want - 1 : 1))) : -1;
    @(negedge clk); cfg_we = 1'b1; wdata = c;
    @(negedge clk); cfg_we = 1'b0;
    check("R2 srst", srst, c[6]);
    check("R2 trst", trst, c[7]);
    pat = p; nr = 0; tdo = p[0];
    wdata = d; scan_we = 1'b1;
    @(negedge clk); scan_we = 1'b0;
    check("R8 busy after launch", busy, 1'b1);
    cyc = 0;
    while (busy && cyc < 1000) begin
      cyc++;
      if (cyc == 1) check("R10 result held", rdata, prev_res);
      if (cyc == inj) begin
        cfg_we = 1'b1; scan_we = 1'b1; wdata = ~c;
      end else begin
        cfg_we = 1'b0; scan_we = 1'b0; wdata = d;
      end
      @(negedge clk);
    end
    cfg_we = 1'b0; scan_we = 1'b0;
    check("R6 R8 busy cycles", cyc, want);
    check("R3 tck rises", nr, n);
    check(c[3] ? "R5 tms scan bits" : "R4 tdi scan bits", bits_ok(c, d, n), 1'b1);
    check("R7 captured tdo", rdata, exp_result(p, n));
    check("R6 tck idle low", tck, 1'b0);
    if (inject) begin
      check("R9 srst kept", srst, c[6]);
      check("R9 trst kept", trst, c[7]);
      repeat (3) @(negedge clk);
      check("R9 no restart", busy, 1'b0);
    end
    prev_res = exp_result(p, n);
  endtask

  initial begin
    void'($urandom(32'd1867));
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 pins", {tck, tms, tdi, srst, trst}, 0);
    check("R1 rdata", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    do_scan(8'h30, 8'hA5, 8'h3C, 1'b0);  // R3 code 0 -> 8 bits, slowest divider
    do_scan(8'h09, 8'h80, 8'h01, 1'b0);  // R5 single TMS bit, tdi from bit 7
    do_scan(8'hC7, 8'h5A, 8'hFF, 1'b1);  // R9 drops during 7-bit TDI scan
    do_scan(8'h4B, 8'h7F, 8'h00, 1'b1);  // R5 3-bit TMS scan with bit 7 low
    for (int i = 0; i < 40; i++)
      do_scan(8'($urandom), 8'($urandom), 8'($urandom), bit'($urandom % 2));
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule